// File: doc/BRIEF.md
# Page-Bounded Flash Program Splitter

This block turns one host write request, a start byte address and a byte count, into a series of page-program commands for a serial NOR flash. No command carries bytes from two pages: each chunk is cut at the next page boundary or at the end of the request, whichever comes first. A write that starts in the middle of a page therefore produces a short first chunk.

For each chunk the block presents an opcode, an address and a chunk length on a command handshake. It then passes exactly that many payload bytes from the host byte stream to the downstream byte stream, and waits for a program-done pulse from the flash side before it issues the next chunk. The page size (256 or 512 bytes) and the address width (3 or 4 bytes) are selected for each request. An advisory flag reports requests that are not aligned to 16 bytes. The flag does not stop the write.

Top module: `flash_page_splitter`

## Requirements
- R1: Each chunk length `cmd_len` equals min(page_size − (address mod page_size), bytes remaining). It is never zero.
- R2: A chunk never crosses a page boundary: (cmd_addr mod page_size) + cmd_len ≤ page_size.
- R3: `req_page512` = 0 selects a 256-byte page and 1 selects a 512-byte page. The choice is latched when the request is accepted.
- R4: With `req_addr4` = 0 the opcode is 8'h02 and `cmd_addr` carries only the low 24 address bits, with the upper bits zero. With `req_addr4` = 1 the opcode is 8'h12 and `cmd_addr` carries the full address. While `cmd_valid` waits for `cmd_ready`, the command fields stay stable.
- R5: After a command handshake, exactly `cmd_len` bytes move from `in_data` to `out_data` in order, each on a cycle where `in_valid` and `out_ready` are both high. Outside the payload phase, `in_ready` and `out_valid` are low.
- R6: After the last payload byte of a chunk, no command is issued and no byte is accepted until `prog_done` is seen.
- R7: After each chunk the address advances and the remaining count drops by the chunk length. `done` pulses for one cycle, on the cycle after the `prog_done` that ends the last chunk.
- R8: A zero-length request pulses `done` on the cycle after it is accepted and issues no command.
- R9: `req_ready` is high only while idle. A request offered during a sequence is ignored: it changes neither the commands nor `misalign`.
- R10: `misalign` is set when the request is accepted if the address bits [3:0] or the length bits [3:0] are non-zero, and cleared otherwise. It holds until the next accepted request and never blocks the write.
- R11: After reset, `req_ready` = 1 and `cmd_valid`, `in_ready`, `done` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_page512 | input | 1 | 1 = 512-byte page, 0 = 256-byte page |
| req_addr4 | input | 1 | 1 = 4-byte address mode, 0 = 3-byte |
| misalign | output | 1 | Request not aligned to 16 bytes |
| cmd_valid | output | 1 | Program command valid |
| cmd_ready | input | 1 | Command taken |
| cmd_opcode | output | 8 | Program opcode |
| cmd_addr | output | ADDR_W | Chunk start address |
| cmd_len | output | 10 | Chunk length in bytes |
| in_valid | input | 1 | Host payload byte valid |
| in_ready | output | 1 | Host payload byte taken |
| in_data | input | 8 | Host payload byte |
| out_valid | output | 1 | Payload byte toward flash valid |
| out_ready | input | 1 | Flash side takes byte |
| out_data | output | 8 | Payload byte toward flash |
| prog_done | input | 1 | Pulse: page program finished |
| done | output | 1 | Pulse: whole request finished |

## Verification
On every cycle the assertions check that a presented chunk stays inside its page and is non-zero and no longer than the remaining count. They also check that the opcode matches the address mode, that a stalled command holds its fields, that the byte count never reaches the chunk length, that no command appears while idle or while waiting for program completion, and that `done` lasts one cycle. Only the bench's scenarios can show the actual chunk sequence for a given address, length and page size: the split at 256 versus 512 bytes, the truncation of the address in 3-byte mode, byte order through the payload path, the zero-length shortcut, the misalignment flag value, and that a request offered mid-sequence is ignored.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam int CHUNK_W = 10;

  localparam logic [7:0] OP_PROG_3B = 8'h02;
  localparam logic [7:0] OP_PROG_4B = 8'h12;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_ISSUE  = 3'd1,
    SQ_STREAM = 3'd2,
    SQ_WAITPD = 3'd3,
    SQ_FINISH = 3'd4
  } seq_state_t;

  function automatic logic [CHUNK_W-1:0] page_bytes(input logic big_page);
    page_bytes = big_page ? CHUNK_W'(512) : CHUNK_W'(256);
  endfunction

  // bytes from an offset to the end of the page it falls in
  function automatic logic [CHUNK_W-1:0] room_in_page(input logic [8:0] low_addr,
                                                       input logic       big_page);
    logic [CHUNK_W-1:0] offs;
    offs = big_page ? {1'b0, low_addr} : {2'b00, low_addr[7:0]};
    room_in_page = page_bytes(big_page) - offs;
  endfunction

  function automatic logic [7:0] prog_opcode(input logic wide_addr);
    prog_opcode = wide_addr ? OP_PROG_4B : OP_PROG_3B;
  endfunction

  function automatic logic nibble_off(input logic [3:0] a, input logic [3:0] l);
    nibble_off = (a != 4'd0) || (l != 4'd0);
  endfunction

endpackage

// File: rtl/fps_chunk_calc.sv
module fps_chunk_calc
  import fps_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic [8:0]         low_addr,
  input  logic [LEN_W-1:0]   rem_bytes,
  input  logic               big_page,
  output logic [CHUNK_W-1:0] chunk_len,
  output logic [CHUNK_W-1:0] page_room
);

  localparam int PAD_W = LEN_W - CHUNK_W;

  logic rem_fits;

  always_comb begin
    page_room = room_in_page(low_addr, big_page);
    rem_fits  = rem_bytes < {{PAD_W{1'b0}}, page_room};
    chunk_len = rem_fits ? rem_bytes[CHUNK_W-1:0] : page_room;
  end

endmodule

// File: rtl/fps_byte_path.sv
module fps_byte_path
  import fps_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_phase,
  input  logic [CHUNK_W-1:0] chunk_len,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               payload_last
);

  logic [CHUNK_W-1:0] sent_cnt;
  logic               byte_xfer;

  assign in_ready     = data_phase && out_ready;
  assign out_valid    = data_phase && in_valid;
  assign out_data     = in_data;
  assign byte_xfer    = data_phase && in_valid && out_ready;
  assign payload_last = byte_xfer && (sent_cnt == chunk_len - CHUNK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sent_cnt <= '0;
    else if (!data_phase)  sent_cnt <= '0;
    else if (byte_xfer)    sent_cnt <= sent_cnt + CHUNK_W'(1);
  end

  AST_NO_BYTES_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |-> (!in_ready && !out_valid)); // R5

  AST_COUNT_BELOW_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> (sent_cnt < chunk_len)); // R5

endmodule

// File: rtl/fps_seq.sv
module fps_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_page512,
  input  logic               req_addr4,
  input  logic               cmd_ready,
  input  logic               payload_last,
  input  logic               prog_done,
  input  logic [CHUNK_W-1:0] chunk_len,
  output logic               cmd_valid,
  output logic               data_phase,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [LEN_W-1:0]   rem_bytes,
  output logic               big_page_q,
  output logic               wide_addr_q,
  output logic               done,
  output logic               misalign
);

  seq_state_t state, state_nx;
  logic       req_take;
  logic       cmd_take;
  logic       seq_over;

  assign req_ready  = (state == SQ_IDLE);
  assign cmd_valid  = (state == SQ_ISSUE);
  assign data_phase = (state == SQ_STREAM);
  assign done       = (state == SQ_FINISH);
  assign req_take   = req_valid && req_ready;
  assign cmd_take   = cmd_valid && cmd_ready;
  assign seq_over   = (rem_bytes == '0);

  always_comb begin
    state_nx = state;
    case (state)
      SQ_IDLE:   if (req_take) state_nx = (req_len == '0) ? SQ_FINISH : SQ_ISSUE;
      SQ_ISSUE:  if (cmd_take) state_nx = SQ_STREAM;
      SQ_STREAM: if (payload_last) state_nx = SQ_WAITPD;
      SQ_WAITPD: if (prog_done) state_nx = seq_over ? SQ_FINISH : SQ_ISSUE;
      SQ_FINISH: state_nx = SQ_IDLE;
      default:   state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr    <= '0;
      rem_bytes   <= '0;
      big_page_q  <= 1'b0;
      wide_addr_q <= 1'b0;
      misalign    <= 1'b0;
    end else if (req_take) begin
      cur_addr    <= req_addr;
      rem_bytes   <= req_len;
      big_page_q  <= req_page512;
      wide_addr_q <= req_addr4;
      misalign    <= nibble_off(req_addr[3:0], req_len[3:0]);
    end else if (payload_last) begin
      cur_addr    <= cur_addr + ADDR_W'(chunk_len);
      rem_bytes   <= rem_bytes - LEN_W'(chunk_len);
    end
  end

  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid); // R9

  AST_EMPTY_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && req_len == '0) |=> (done && !cmd_valid)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_HOLD_UNTIL_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAITPD && !prog_done) |=> (!cmd_valid && !data_phase)); // R6

  AST_LAST_CLEARS_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (payload_last && LEN_W'(chunk_len) == rem_bytes) |=> seq_over); // R7

endmodule

// File: rtl/flash_page_splitter.sv
module flash_page_splitter
  import fps_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_page512,
  input  logic               req_addr4,
  output logic               misalign,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [7:0]         cmd_opcode,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [CHUNK_W-1:0] cmd_len,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  input  logic               prog_done,
  output logic               done
);

  localparam int NARROW_W = 24;

  logic               data_phase;
  logic               payload_last;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   rem_bytes;
  logic               big_page_q;
  logic               wide_addr_q;
  logic [CHUNK_W-1:0] chunk_len;
  logic [CHUNK_W-1:0] page_room;

  function automatic logic [ADDR_W-1:0] visible_addr(input logic [ADDR_W-1:0] a,
                                                     input logic              wide);
    logic [ADDR_W-1:0] keep;
    keep = wide ? {ADDR_W{1'b1}} : ADDR_W'({NARROW_W{1'b1}});
    visible_addr = a & keep;
  endfunction

  fps_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .req_page512  (req_page512),
    .req_addr4    (req_addr4),
    .cmd_ready    (cmd_ready),
    .payload_last (payload_last),
    .prog_done    (prog_done),
    .chunk_len    (chunk_len),
    .cmd_valid    (cmd_valid),
    .data_phase   (data_phase),
    .cur_addr     (cur_addr),
    .rem_bytes    (rem_bytes),
    .big_page_q   (big_page_q),
    .wide_addr_q  (wide_addr_q),
    .done         (done),
    .misalign     (misalign)
  );

  fps_chunk_calc #(.LEN_W(LEN_W)) u_calc (
    .low_addr  (cur_addr[8:0]),
    .rem_bytes (rem_bytes),
    .big_page  (big_page_q),
    .chunk_len (chunk_len),
    .page_room (page_room)
  );

  fps_byte_path u_bytes (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_phase   (data_phase),
    .chunk_len    (chunk_len),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .payload_last (payload_last)
  );

  assign cmd_opcode = prog_opcode(wide_addr_q);
  assign cmd_addr   = visible_addr(cur_addr, wide_addr_q);
  assign cmd_len    = chunk_len;

  AST_CHUNK_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ({1'b0, page_bytes(big_page_q)} >=
                   {1'b0, page_bytes(big_page_q) - page_room} + {1'b0, cmd_len})); // R2

  AST_CHUNK_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0 && LEN_W'(cmd_len) <= rem_bytes)); // R1

  AST_OPCODE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (wide_addr_q ? cmd_opcode == 8'h12 : cmd_opcode == 8'h02)); // R4

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_len) && $stable(cmd_opcode))); // R4

endmodule

// File: tb/flash_page_splitter_test.sv
module flash_page_splitter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [23:0] req_len = '0;
  logic        req_page512 = 1'b0;
  logic        req_addr4 = 1'b0;
  logic        misalign;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_opcode;
  logic [31:0] cmd_addr;
  logic [9:0]  cmd_len;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        prog_done = 1'b0;
  logic        done;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_page_splitter uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Drives one request and checks every chunk against a model of R1/R3/R4.
  task automatic run_write(input logic [31:0] a, input logic [23:0] len,
                           input bit p512, input bit a4, input bit disturb);
    longint ra, rem, pg, room, c;
    bit exp_mis;
    int bad_bytes, bad_wait, nchunk;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_len = len; req_page512 = p512; req_addr4 = a4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    #1;
    exp_mis = (a[3:0] != 0) || (len[3:0] != 0);
    check(misalign == exp_mis, "R10 misalign", misalign, exp_mis);
    if (len == 0) begin
      check(done == 1 && cmd_valid == 0, "R8 zero-length done", {done, cmd_valid}, 2'b10);
      @(negedge clk); #1;
      check(done == 0 && req_ready == 1, "R8 back to idle", {done, req_ready}, 2'b01);
      return;
    end
    check(req_ready == 0, "R9 busy", req_ready, 0);
    ra = a; rem = len; nchunk = 0;
    while (rem > 0) begin
      pg = p512 ? 512 : 256;
      room = pg - (ra % pg);
      c = (rem < room) ? rem : room;
      for (int k = 0; k < 16 && !cmd_valid; k++) begin
        @(negedge clk); #1;
      end
      check(cmd_valid == 1, "R6 command issued", cmd_valid, 1);
      check(cmd_len == c[9:0], "R1 chunk length", cmd_len, c);
      check(cmd_addr == (a4 ? ra[31:0] : (ra[31:0] & 32'h00FF_FFFF)), "R4 address",
            cmd_addr, a4 ? ra : (ra & 32'h00FF_FFFF));
      check(cmd_opcode == (a4 ? 8'h12 : 8'h02), "R4 opcode", cmd_opcode, a4 ? 8'h12 : 8'h02);
      if (disturb && nchunk == 0) begin
        req_valid = 1; req_addr = 32'h0000_0007; req_len = 0;
      end
      @(negedge clk); #1;
      check(cmd_valid == 1, "R4 stall hold", cmd_valid, 1);
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
      bad_bytes = 0;
      for (int i = 0; i < c; i++) begin
        in_valid = 1; in_data = 8'(ra + i + 8'h5A); out_ready = 1;
        #1;
        if (!(out_valid && in_ready && out_data == 8'(ra + i + 8'h5A))) bad_bytes++;
        @(negedge clk);
      end
      check(bad_bytes == 0, "R5 payload bytes", bad_bytes, 0);
      if (disturb && nchunk == 0) req_valid = 0;
      bad_wait = 0;
      for (int w = 0; w < 3; w++) begin
        #1;
        if (cmd_valid || in_ready || out_valid) bad_wait++;
        @(negedge clk);
      end
      check(bad_wait == 0, "R6 hold until program done", bad_wait, 0);
      in_valid = 0; out_ready = 0;
      prog_done = 1;
      @(negedge clk);
      prog_done = 0;
      #1;
      ra += c; rem -= c; nchunk++;
    end
    check(done == 1 && cmd_valid == 0, "R7 done pulse", {done, cmd_valid}, 2'b10);
    @(negedge clk); #1;
    check(done == 0 && req_ready == 1, "R7 single-cycle done", {done, req_ready}, 2'b01);
    check(misalign == exp_mis, "R9 misalign unchanged", misalign, exp_mis);
  endtask

  task automatic t_reset();
    #1;
    check(req_ready == 1 && cmd_valid == 0 && in_ready == 0 && done == 0 && misalign == 0,
          "R11 reset state", {req_ready, cmd_valid, in_ready, done, misalign}, 5'b10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    // full aligned page, 3-byte mode
    run_write(32'h0000_0100, 24'd256, 0, 0, 0);
    // wrap case split at the 256 boundary, upper byte dropped in 3-byte mode (R2)
    run_write(32'hAB00_00FE, 24'd3, 0, 0, 0);
    // same span with 512-byte page: two chunks (R3)
    run_write(32'h1200_0140, 24'h200, 1, 1, 0);
    // same span with 256-byte page: three chunks, stray request ignored (R3, R9)
    run_write(32'h1200_0140, 24'h200, 0, 1, 1);
    // zero length
    run_write(32'h0000_0010, 24'd0, 0, 0, 0);
    // length-only misalignment, write still runs (R10)
    run_write(32'h0000_0000, 24'd5, 1, 0, 0);
    report();
  end

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

endmodule